// File: doc/BRIEF.md
# Per-CPU Interrupt Pending Bank

This block holds one 32-bit pending-interrupt word for each processor in the system, sixteen by default. A word-addressed register bus reaches every word. Each processor's registers sit in a separate 4 KB page of the address space. Through the bus, software reads a processor's pending word, raises soft interrupt bits in it and clears bits from it. Only the upper fifteen bits, 31 down to 17, can be written from the bus.

Hardware interrupt sources drive a single event port. Each event carries a priority between 1 and 15, a direction (assert or deassert) and a destination processor. An all-ones destination means "the processor currently targeted", which a separate routing block supplies. An assert sets the bit at the priority position of the chosen word, and a deassert clears that bit.

For every processor the block keeps a registered 4-bit soft level and a request line. The level is taken from the highest pending bit in positions 31 to 17, and the request is raised whenever that level is nonzero.

Top module: `cpu_irq_pending_bank`

## Requirements
- R1: A synchronous reset clears every pending word and drives every level and request output to zero.
- R2: The processor index comes from bus_addr[15:12] and the word offset from bus_addr[3:2]. A read at offset 0 returns that processor's pending word, combinationally. Offsets 1, 2 and 3 read as zero.
- R3: A write at offset 1 clears, in the addressed word, every bit that is set in bus_wdata & 0xFFFE0000. All other bits keep their value.
- R4: A write at offset 2 sets, in the addressed word, the bits of bus_wdata & 0xFFFE0000. Bits 16..0 of the written value have no effect. Writes at offsets 0 and 3 change nothing.
- R5: When a clear write (offset 1) has bus_wdata[14] set, pending bit 31 is cleared as well.
- R6: A processor's level output is j-16, where j is the highest set bit among bits 31..17 of its pending word. It is 0 when none of those bits is set. The level is registered and changes on the same clock edge as the pending word it reflects.
- R7: A processor's request output is 1 exactly when its level output is nonzero.
- R8: A hardware event with hw_valid=1 and nonzero priority p sets bit p of the destination word when hw_assert=1, and clears it when hw_assert=0. A priority of 0 has no effect.
- R9: A hardware destination index of all ones (15) selects the processor given by target_cpu. Any other index selects that processor directly.
- R10: A bus write or hardware event changes only the destination processor's word. When a bus write and a hardware event hit the same cycle, both take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Byte address; [15:12] processor, [3:2] word offset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| hw_valid | input | 1 | Hardware event strobe |
| hw_assert | input | 1 | 1 = source asserted, 0 = source deasserted |
| hw_prio | input | 4 | Priority of the event source (0 = none) |
| hw_cpu | input | 4 | Destination processor, all ones = targeted processor |
| target_cpu | input | 4 | Currently targeted processor |
| irq_req | output | 16 | Per-processor request, registered |
| irq_level | output | 64 | Per-processor 4-bit level, processor i at [4i+3:4i] |

## Verification
The clear and raise properties assume that hardware events touch only bits 1..15, while bus writes touch only bits 17..31. Because of this, a bus write's effect can be checked on the next cycle without regard to a simultaneous hardware event. The stimulus keeps hw_prio within four bits, so this separation always holds. It also keeps target_cpu inside the populated processor range, so every routed event lands in a real word. The random phase mixes all four offsets, every processor and the all-ones destination. A cycle-accurate behavioural model checks every output, including same-cycle bus and hardware traffic.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;

    localparam int WORD_W    = 32;
    localparam int LVL_W     = 4;
    localparam int OFS_W     = 2;
    localparam int OFS_LSB   = 2;
    localparam int SOFT_LO   = 17;
    localparam int SOFT_HI   = 31;
    localparam int ALIAS_BIT = 14;
    localparam logic [WORD_W-1:0] SOFT_MASK = 32'hFFFE_0000;

    typedef enum logic [OFS_W-1:0] {
        OFS_STATUS = 2'd0,
        OFS_CLEAR  = 2'd1,
        OFS_RAISE  = 2'd2,
        OFS_SPARE  = 2'd3
    } pend_ofs_e;

    typedef struct packed {
        logic [WORD_W-1:0] set_m;
        logic [WORD_W-1:0] clr_m;
    } pend_upd_t;

    // bits a raise write may set
    function automatic logic [WORD_W-1:0] raise_filter(input logic [WORD_W-1:0] v);
        return v & SOFT_MASK;
    endfunction

    // bits a clear write removes; bit 14 aliases onto bit 31
    function automatic logic [WORD_W-1:0] clear_filter(input logic [WORD_W-1:0] v);
        logic [WORD_W-1:0] t;
        t = v;
        t[SOFT_HI] = v[SOFT_HI] | v[ALIAS_BIT];
        return t & SOFT_MASK;
    endfunction

    // highest pending soft bit, expressed as a level
    function automatic logic [LVL_W-1:0] soft_level(input logic [WORD_W-1:0] w);
        logic [LVL_W-1:0] lvl;
        lvl = '0;
        for (int j = SOFT_LO; j <= SOFT_HI; j++) begin
            if (w[j]) lvl = LVL_W'(j - SOFT_LO + 1);
        end
        return lvl;
    endfunction

    // one-hot pending bit for a hardware priority, none for zero
    function automatic logic [WORD_W-1:0] prio_bit(input logic [LVL_W-1:0] prio);
        logic [WORD_W-1:0] m;
        m = '0;
        if (prio != '0) m[prio] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/pend_bus_decode.sv
module pend_bus_decode
    import irq_pend_pkg::*;
#(
    parameter int NUM_CPU = 16,
    parameter int CPU_W   = 4
) (
    input  logic              bus_wr,
    input  logic [CPU_W-1:0]  bus_cpu,
    input  pend_ofs_e         bus_ofs,
    input  logic [WORD_W-1:0] bus_wdata,
    output pend_upd_t         upd [NUM_CPU]
);

    logic [WORD_W-1:0] raise_v;
    logic [WORD_W-1:0] clear_v;
    logic              do_raise;
    logic              do_clear;

    always_comb begin
        raise_v  = raise_filter(bus_wdata);
        clear_v  = clear_filter(bus_wdata);
        do_raise = bus_wr && (bus_ofs == OFS_RAISE);
        do_clear = bus_wr && (bus_ofs == OFS_CLEAR);
    end

    for (genvar gi = 0; gi < NUM_CPU; gi++) begin : g_dec
        logic hit;
        assign hit     = (bus_cpu == CPU_W'(gi));
        assign upd[gi] = {(do_raise && hit) ? raise_v : '0,
                          (do_clear && hit) ? clear_v : '0};
    end

endmodule

// File: rtl/pend_hw_route.sv
module pend_hw_route
    import irq_pend_pkg::*;
#(
    parameter int NUM_CPU = 16,
    parameter int CPU_W   = 4
) (
    input  logic             hw_valid,
    input  logic             hw_assert,
    input  logic [LVL_W-1:0] hw_prio,
    input  logic [CPU_W-1:0] hw_cpu,
    input  logic [CPU_W-1:0] target_cpu,
    output pend_upd_t        upd [NUM_CPU]
);

    localparam logic [CPU_W-1:0] TO_TARGET = {CPU_W{1'b1}};

    logic [CPU_W-1:0]  dest;
    logic [WORD_W-1:0] bit_m;

    always_comb begin
        dest  = (hw_cpu == TO_TARGET) ? target_cpu : hw_cpu;
        bit_m = prio_bit(hw_prio);
    end

    for (genvar gi = 0; gi < NUM_CPU; gi++) begin : g_route
        logic hit;
        assign hit     = hw_valid && (dest == CPU_W'(gi));
        assign upd[gi] = {(hit &&  hw_assert) ? bit_m : '0,
                          (hit && !hw_assert) ? bit_m : '0};
    end

endmodule

// File: rtl/pend_cpu_slice.sv
module pend_cpu_slice
    import irq_pend_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  pend_upd_t         bus_upd,
    input  pend_upd_t         hw_upd,
    output logic [WORD_W-1:0] pend_q,
    output logic [LVL_W-1:0]  level_q,
    output logic              req_q
);

    logic [WORD_W-1:0] pend_d;

    // order: bus raise, hardware, bus clear last
    always_comb begin
        pend_d = pend_q | bus_upd.set_m | hw_upd.set_m;
        pend_d = pend_d & ~hw_upd.clr_m;
        pend_d = pend_d & ~bus_upd.clr_m;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= '0;
            level_q <= '0;
            req_q   <= 1'b0;
        end else begin
            pend_q  <= pend_d;
            level_q <= soft_level(pend_d);
            req_q   <= (pend_d & SOFT_MASK) != '0;
        end
    end

endmodule

// File: rtl/cpu_irq_pending_bank.sv
module cpu_irq_pending_bank
    import irq_pend_pkg::*;
#(
    parameter int NUM_CPU  = 16,
    parameter int CPU_W    = 4,
    parameter int ADDR_W   = 16,
    parameter int PAGE_LSB = 12
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic                     bus_wr,
    input  logic [WORD_W-1:0]        bus_wdata,
    output logic [WORD_W-1:0]        bus_rdata,
    input  logic                     hw_valid,
    input  logic                     hw_assert,
    input  logic [LVL_W-1:0]         hw_prio,
    input  logic [CPU_W-1:0]         hw_cpu,
    input  logic [CPU_W-1:0]         target_cpu,
    output logic [NUM_CPU-1:0]       irq_req,
    output logic [NUM_CPU*LVL_W-1:0] irq_level
);

    logic [CPU_W-1:0]          bus_cpu;
    pend_ofs_e                 bus_ofs;
    logic                      addr_unused;
    pend_upd_t                 bus_upd [NUM_CPU];
    pend_upd_t                 hw_upd  [NUM_CPU];
    logic [WORD_W-1:0]         pend_word [NUM_CPU];
    logic [NUM_CPU*WORD_W-1:0] pend_flat;

    assign bus_cpu     = bus_addr[PAGE_LSB +: CPU_W];
    assign bus_ofs     = pend_ofs_e'(bus_addr[OFS_LSB +: OFS_W]);
    assign addr_unused = ^bus_addr;

    pend_bus_decode #(.NUM_CPU(NUM_CPU), .CPU_W(CPU_W)) u_dec (
        .bus_wr    (bus_wr),
        .bus_cpu   (bus_cpu),
        .bus_ofs   (bus_ofs),
        .bus_wdata (bus_wdata),
        .upd       (bus_upd)
    );

    pend_hw_route #(.NUM_CPU(NUM_CPU), .CPU_W(CPU_W)) u_route (
        .hw_valid   (hw_valid),
        .hw_assert  (hw_assert),
        .hw_prio    (hw_prio),
        .hw_cpu     (hw_cpu),
        .target_cpu (target_cpu),
        .upd        (hw_upd)
    );

    for (genvar gi = 0; gi < NUM_CPU; gi++) begin : g_cpu
        pend_cpu_slice u_slice (
            .clk     (clk),
            .rst     (rst),
            .bus_upd (bus_upd[gi]),
            .hw_upd  (hw_upd[gi]),
            .pend_q  (pend_word[gi]),
            .level_q (irq_level[gi*LVL_W +: LVL_W]),
            .req_q   (irq_req[gi])
        );
        assign pend_flat[gi*WORD_W +: WORD_W] = pend_word[gi];
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_CPU; i++) begin
            if (bus_cpu == CPU_W'(i) && bus_ofs == OFS_STATUS) bus_rdata = pend_word[i];
        end
    end

endmodule

// File: rtl/pend_bank_checker.sv
module pend_bank_checker #(
    parameter int NUM_CPU = 16,
    parameter int CPU_W   = 4
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  wr,
    input logic [CPU_W-1:0]      cpu,
    input logic [1:0]            ofs,
    input logic [14:0]           set_bits,
    input logic                  alias_b,
    input logic [NUM_CPU-1:0]    irq_req,
    input logic [NUM_CPU*4-1:0]  irq_level,
    input logic [NUM_CPU*32-1:0] pend_flat
);

    // R1: reset leaves all words and requests cleared
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (irq_req == '0 && pend_flat == '0));

    for (genvar k = 0; k < NUM_CPU; k++) begin : g_chk
        logic [31:0] pw;
        logic [3:0]  lv;
        logic [31:0] raise_m;
        logic [31:0] clr_m;
        logic [5:0]  top_pos;
        assign pw      = pend_flat[k*32 +: 32];
        assign lv      = irq_level[k*4 +: 4];
        assign raise_m = {set_bits, 17'b0};
        assign clr_m   = {set_bits[14] | alias_b, set_bits[13:0], 17'b0};
        assign top_pos = 6'(lv) + 6'd16;

        // R4: raised bits are present one cycle later
        a_r4_raise_lands: assert property (@(posedge clk) disable iff (rst)
            (wr && cpu == CPU_W'(k) && ofs == 2'd2) |=> ((pw & $past(raise_m)) == $past(raise_m)));

        // R3, R5: cleared bits (with alias) are gone one cycle later
        a_r3_clear_lands: assert property (@(posedge clk) disable iff (rst)
            (wr && cpu == CPU_W'(k) && ofs == 2'd1) |=> ((pw & $past(clr_m)) == '0));

        // R6: nonzero level exactly when a soft bit is pending
        a_r6_level_zero: assert property (@(posedge clk) disable iff (rst)
            (lv != 4'd0) == (pw[31:17] != 15'd0));

        // R6: level points at a set bit with nothing above it
        a_r6_level_top: assert property (@(posedge clk) disable iff (rst)
            (lv != 4'd0) |-> (pw[top_pos[4:0]] && ((pw >> (top_pos + 6'd1)) == '0)));

        // R7: request follows level
        a_r7_req_level: assert property (@(posedge clk) disable iff (rst)
            irq_req[k] == (lv != 4'd0));
    end

endmodule

bind cpu_irq_pending_bank pend_bank_checker #(.NUM_CPU(NUM_CPU), .CPU_W(CPU_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr        (bus_wr),
    .cpu       (bus_addr[PAGE_LSB +: CPU_W]),
    .ofs       (bus_addr[3:2]),
    .set_bits  (bus_wdata[31:17]),
    .alias_b   (bus_wdata[14]),
    .irq_req   (irq_req),
    .irq_level (irq_level),
    .pend_flat (pend_flat)
);

// File: tb/cpu_irq_pending_bank_bench.sv
`timescale 1ns/1ps
module cpu_irq_pending_bank_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        hw_valid = 1'b0;
    logic        hw_assert = 1'b0;
    logic [3:0]  hw_prio = '0;
    logic [3:0]  hw_cpu = '0;
    logic [3:0]  target_cpu = '0;
    logic [15:0] irq_req;
    logic [63:0] irq_level;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [31:0] m [16];

    always #2.5 clk = ~clk;

    cpu_irq_pending_bank u_cpu_irq_pending_bank (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_valid(hw_valid),
        .hw_assert(hw_assert), .hw_prio(hw_prio), .hw_cpu(hw_cpu),
        .target_cpu(target_cpu), .irq_req(irq_req), .irq_level(irq_level)
    );

    function automatic int exp_level(input logic [31:0] w);
        for (int j = 31; j >= 17; j--) if (w[j]) return j - 16;
        return 0;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural model: raise, hardware, then clear
    task automatic model_update();
        logic [31:0] cm;
        int c;
        int d;
        int ofs;
        c = int'(bus_addr[15:12]);
        ofs = int'(bus_addr[3:2]);
        if (rst) begin
            for (int i = 0; i < 16; i++) m[i] = '0;
        end else begin
            if (bus_wr && ofs == 2) m[c] = m[c] | (bus_wdata & 32'hFFFE0000);
            if (hw_valid && hw_prio != 0) begin
                d = (hw_cpu == 4'hF) ? int'(target_cpu) : int'(hw_cpu);
                if (hw_assert) m[d] = m[d] | (32'd1 << hw_prio);
                else           m[d] = m[d] & ~(32'd1 << hw_prio);
            end
            if (bus_wr && ofs == 1) begin
                cm = bus_wdata;
                if (cm[14]) cm[31] = 1'b1;
                m[c] = m[c] & ~(cm & 32'hFFFE0000);
            end
        end
    endtask

    task automatic compare_all();
        logic [31:0] er;
        for (int i = 0; i < 16; i++) begin
            check($sformatf("R6 level cpu%0d", i), 32'(irq_level[i*4 +: 4]), 32'(exp_level(m[i])));
            check($sformatf("R7 req cpu%0d", i), 32'(irq_req[i]), 32'(exp_level(m[i]) != 0));
        end
        er = (bus_addr[3:2] == 2'd0) ? m[bus_addr[15:12]] : 32'd0;
        check("R2 rdata", bus_rdata, er);
    endtask

    task automatic tick();
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare_all();
    endtask

    task automatic quiet();
        bus_wr = 1'b0;
        hw_valid = 1'b0;
    endtask

    task automatic bus_write(input int c, input int o, input logic [31:0] d);
        bus_addr = {4'(c), 8'h00, 2'(o), 2'b00};
        bus_wdata = d;
        bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic hw_event(input int c, input int p, input bit a);
        hw_cpu = 4'(c);
        hw_prio = 4'(p);
        hw_assert = a;
        hw_valid = 1'b1;
        tick();
        hw_valid = 1'b0;
    endtask

    task automatic read_chk(input string tag, input int c, input int o, input logic [31:0] exp);
        quiet();
        bus_addr = {4'(c), 8'h00, 2'(o), 2'b00};
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic lvl_chk(input string tag, input int c, input int exp);
        check(tag, 32'(irq_level[c*4 +: 4]), 32'(exp));
        check(tag, 32'(irq_req[c]), 32'(exp != 0));
    endtask

    initial begin
        for (int i = 0; i < 16; i++) m[i] = '0;
        @(negedge clk);
        tick();
        tick();
        rst = 1'b0;
        tick();
        // R1: reset state
        read_chk("R1 reset cpu0", 0, 0, 32'h0);
        check("R1 reset req", 32'(irq_req), 32'h0);

        // R4 / R6 / R7: raise all writable bits of cpu3
        bus_write(3, 2, 32'hFFFF_FFFF);
        read_chk("R4 raise mask", 3, 0, 32'hFFFE_0000);
        lvl_chk("R6 level 15", 3, 15);
        read_chk("R10 cpu4 untouched", 4, 0, 32'h0);

        // R3: clear bit 31
        bus_write(3, 1, 32'h8000_0000);
        read_chk("R3 clear bit31", 3, 0, 32'h7FFE_0000);
        lvl_chk("R6 level 14", 3, 14);

        // R5: bit 14 alias clears bit 31
        bus_write(3, 2, 32'h8000_0000);
        bus_write(3, 1, 32'h0000_4000);
        read_chk("R5 alias clear", 3, 0, 32'h7FFE_0000);

        // R3 / R6: leave only bit 17
        bus_write(3, 1, 32'h7FFC_0000);
        read_chk("R3 partial clear", 3, 0, 32'h0002_0000);
        lvl_chk("R6 level 1 boundary", 3, 1);

        // R4: bit 16 and below ignored
        bus_write(5, 2, 32'h0001_FFFF);
        read_chk("R4 low bits ignored", 5, 0, 32'h0);
        lvl_chk("R6 level 0", 5, 0);

        // R2 / R4: other offsets
        read_chk("R2 offset3 zero", 3, 3, 32'h0);
        read_chk("R2 offset1 zero", 3, 1, 32'h0);
        bus_write(7, 0, 32'hFFFF_FFFF);
        bus_write(7, 3, 32'hFFFF_FFFF);
        read_chk("R4 offsets 0,3 inert", 7, 0, 32'h0);

        // R8: hardware set / clear / zero priority
        hw_event(2, 9, 1'b1);
        read_chk("R8 hw set", 2, 0, 32'h0000_0200);
        lvl_chk("R8 hw bit no soft level", 2, 0);
        hw_event(2, 0, 1'b1);
        read_chk("R8 prio0 inert", 2, 0, 32'h0000_0200);
        hw_event(2, 9, 1'b0);
        read_chk("R8 hw clear", 2, 0, 32'h0);

        // R9: all-ones destination goes to target
        target_cpu = 4'd6;
        hw_event(15, 5, 1'b1);
        read_chk("R9 routed to target", 6, 0, 32'h0000_0020);
        read_chk("R9 cpu15 untouched", 15, 0, 32'h0);

        // R10: bus and hw on same cycle, same cpu
        bus_addr = {4'd6, 8'h00, 2'd2, 2'b00};
        bus_wdata = 32'h0010_0000;
        bus_wr = 1'b1;
        hw_cpu = 4'd6; hw_prio = 4'd3; hw_assert = 1'b1; hw_valid = 1'b1;
        tick();
        read_chk("R10 same cycle both", 6, 0, 32'h0010_0028);

        // random traffic against the model
        for (int n = 0; n < 400; n++) begin
            bus_addr = {4'($urandom_range(0, 15)), 8'($urandom), 2'($urandom), 2'($urandom)};
            bus_wdata = $urandom;
            bus_wr = 1'($urandom);
            hw_valid = 1'($urandom);
            hw_assert = 1'($urandom);
            hw_prio = 4'($urandom);
            hw_cpu = 4'($urandom);
            target_cpu = 4'($urandom_range(0, 14));
            tick();
        end
        quiet();

        // R1: mid-run reset
        rst = 1'b1;
        tick();
        rst = 1'b0;
        tick();
        check("R1 mid reset req", 32'(irq_req), 32'h0);
        check("R1 mid reset level", irq_level[31:0] | irq_level[63:32], 32'h0);
        read_chk("R1 mid reset cpu3", 3, 0, 32'h0);

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule